// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets on-chip logic read and write a 256K-word by 16-bit asynchronous static RAM through a single-clock request/acknowledge port. A requester presents an 18-bit word address, write data, two byte-lane enables and a read/write flag, and holds `req` high until `ack` pulses. The controller captures the request, runs one complete memory cycle on the memory pins, and pulses `ack` for one cycle when that cycle is over. For reads, it pulses `rd_valid` in the same cycle and returns the read data, with disabled lanes forced to zero.

All memory timing is counted in clock cycles. Each nanosecond figure is divided by `CLK_PERIOD_NS` and rounded up, with a floor of one cycle. With the default 10 ns clock, a read holds output enable low for 7 cycles. Once it is deselected, 3 float cycles follow before the controller is idle again. A write takes one address cycle, then a write strobe low for 5 cycles, then one recovery cycle. The controller ends every write on the rising edge of its write strobe. It drives the data bus only while that strobe is low.

The state machine has six states. `ST_IDLE` goes to `ST_RD_ACCESS` or `ST_WR_SETUP` on an accepted request. `ST_RD_ACCESS` goes to `ST_RD_FLOAT` when its timer expires, and `ST_RD_FLOAT` goes to `ST_IDLE` on expiry. `ST_WR_SETUP` goes to `ST_WR_STROBE`, then `ST_WR_RECOVER`, then `ST_IDLE`, each step on timer expiry. A request is accepted only in `ST_IDLE`.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is asserted, both selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_rd_en_n`=1, `mem_wr_strobe_n`=1, `mem_hi_lane_n`=1, `mem_lo_lane_n`=1, `mem_dq_oe`=0, and `ack` and `rd_valid` are 0. This holds even if reset is asserted in the middle of a write.
- R2: A read selects the memory (`mem_sel_n`=0, `mem_sel`=1) and holds `mem_rd_en_n` low for RD_CYC consecutive cycles while `mem_wr_strobe_n` stays high. RD_CYC is the largest of the rounded-up counts for the 70 ns read cycle, the 70 ns address access and the 35 ns output-enable access, which gives 7 at 10 ns. `mem_addr` equals the request address throughout.
- R3: The clock edge that ends the last cycle of the read access window samples `mem_dq_in`. In the cycle after that edge, `ack` and `rd_valid` are both high for exactly one cycle. A read therefore acknowledges RD_CYC+1 cycles after the accepting edge. `rd_valid` never pulses for a write.
- R4: `req_be[1]` enables bits 15:8 and drives `mem_hi_lane_n` low. `req_be[0]` enables bits 7:0 and drives `mem_lo_lane_n` low. Returned read data has zeros in every disabled lane.
- R5: A write spends one cycle with the address and lanes valid and the write strobe high. The strobe then goes low for WP_CYC cycles. WP_CYC is the largest of the counts for the 50 ns write pulse, the 35 ns data setup, and the 60 ns address-to-end-of-write less the setup cycle, which gives 5. The address is then held with the strobe high for max(1, WC_CYC-1-WP_CYC) cycles, where WC_CYC is the count for the 70 ns write cycle. `mem_rd_en_n` stays high for the whole write, and `ack` comes the cycle after, which is 8 cycles after acceptance at 10 ns.
- R6: `mem_dq_oe` is high only while `mem_wr_strobe_n` is low, for exactly WP_CYC cycles per write. It falls in the same cycle the strobe rises, and `mem_dq_out` is unchanged in that cycle.
- R7: A write updates only the enabled byte lanes. A write with both lanes disabled leaves the word unchanged, as a later read shows.
- R8: After a read, the memory is deselected with `mem_rd_en_n` high for FLOAT_CYC cycles, which is 3 (from 25 ns). One idle cycle follows before any new request is accepted. A write that is held pending during a read first drives the bus FLOAT_CYC+3 cycles after the last cycle with `mem_rd_en_n` low.
- R9: Only one request runs at a time. Changes on `req_write`, `req_addr`, `req_be` and `req_wdata` after acceptance have no effect on the running cycle, and `ack` is a single-cycle pulse for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 upper, bit 0 lower |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_en_n | output | 1 | Active-low output enable |
| mem_wr_strobe_n | output | 1 | Active-low write strobe |
| mem_hi_lane_n | output | 1 | Active-low upper byte enable |
| mem_lo_lane_n | output | 1 | Active-low lower byte enable |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench raises `req` just after a falling clock edge, so the following rising edge accepts the request. It then counts falling edges until `ack` appears. That count must be RD_CYC+1 for a read and 1+WP_CYC+tail+1 for a write, and `rd_data` is compared at that same falling edge. Strobe widths, drive cycles and the address are tallied at every falling edge of the access. Those tallies are checked only after the float cycles have elapsed, by which point the last memory pin has returned to its idle level. The turnaround gap is measured from the last falling edge with output enable low to the first with the bus driven, and it must equal FLOAT_CYC+3.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_FLOAT,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RECOVER
    } sram_state_e;

    // Rounded-up cycle count for a nanosecond figure, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_wait_timer.sv
module sram_ctrl_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/sram_ctrl_lane_merge.sv
module sram_ctrl_lane_merge #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] merged
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lane_en[g] ? raw[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC    = 7,
    parameter int FLOAT_CYC = 3,
    parameter int WP_CYC    = 5,
    parameter int WTAIL_CYC = 1,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             rd_last,
    output logic             wr_last,
    output logic             ce_act,
    output logic             oe_act,
    output logic             we_act,
    output logic             drive,
    output logic             lane_act
);

    sram_state_e state_q;
    sram_state_e state_nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:       if (req) state_nxt = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (expired) state_nxt = ST_RD_FLOAT;
            ST_RD_FLOAT:   if (expired) state_nxt = ST_IDLE;
            ST_WR_SETUP:   if (expired) state_nxt = ST_WR_STROBE;
            ST_WR_STROBE:  if (expired) state_nxt = ST_WR_RECOVER;
            ST_WR_RECOVER: if (expired) state_nxt = ST_IDLE;
            default:       state_nxt = ST_IDLE;
        endcase
    end

    // Timer reload on every state change: duration of the state entered, less one.
    always_comb begin
        load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_RD_ACCESS:  load_val = CNT_W'(RD_CYC - 1);
            ST_RD_FLOAT:   load_val = CNT_W'(FLOAT_CYC - 1);
            ST_WR_STROBE:  load_val = CNT_W'(WP_CYC - 1);
            ST_WR_RECOVER: load_val = CNT_W'(WTAIL_CYC - 1);
            default:       load_val = '0;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req;
    assign rd_last = (state_q == ST_RD_ACCESS) && expired;
    assign wr_last = (state_q == ST_WR_RECOVER) && expired;

    // Memory-side strobes decoded from the state.
    always_comb begin
        ce_act   = 1'b0;
        oe_act   = 1'b0;
        we_act   = 1'b0;
        drive    = 1'b0;
        lane_act = 1'b0;
        unique case (state_q)
            ST_RD_ACCESS: begin
                ce_act   = 1'b1;
                oe_act   = 1'b1;
                lane_act = 1'b1;
            end
            ST_WR_SETUP, ST_WR_RECOVER: begin
                ce_act   = 1'b1;
                lane_act = 1'b1;
            end
            ST_WR_STROBE: begin
                ce_act   = 1'b1;
                we_act   = 1'b1;
                drive    = 1'b1;
                lane_act = 1'b1;
            end
            default: begin
                ce_act = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_OHZ_NS      = 25,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 50,
    parameter int T_AW_NS       = 60,
    parameter int T_DW_NS       = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_en_n,
    output logic              mem_wr_strobe_n,
    output logic              mem_hi_lane_n,
    output logic              mem_lo_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int LANES     = DATA_W / 8;
    localparam int RD_CYC    = max2(max2(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                    ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
    localparam int FLOAT_CYC = ns_to_cycles(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int WP_CYC    = max2(max2(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_DW_NS, CLK_PERIOD_NS)),
                                    ns_to_cycles(T_AW_NS, CLK_PERIOD_NS) - 1);
    localparam int WTAIL_CYC = max2(1, ns_to_cycles(T_WC_NS, CLK_PERIOD_NS) - 1 - WP_CYC);
    localparam int MAX_CYC   = max2(max2(RD_CYC, FLOAT_CYC), max2(WP_CYC, WTAIL_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              expired;
    logic              accept;
    logic              rd_last;
    logic              wr_last;
    logic              ce_act;
    logic              oe_act;
    logic              we_act;
    logic              drive;
    logic              lane_act;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;
    logic              rvalid_q;

    sram_ctrl_fsm #(
        .RD_CYC    (RD_CYC),
        .FLOAT_CYC (FLOAT_CYC),
        .WP_CYC    (WP_CYC),
        .WTAIL_CYC (WTAIL_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .accept    (accept),
        .rd_last   (rd_last),
        .wr_last   (wr_last),
        .ce_act    (ce_act),
        .oe_act    (oe_act),
        .we_act    (we_act),
        .drive     (drive),
        .lane_act  (lane_act)
    );

    sram_ctrl_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_ctrl_lane_merge #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_merge (
        .raw     (mem_dq_in),
        .lane_en (be_q),
        .merged  (merged)
    );

    // Request capture: fields are frozen for the whole memory cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be[LANES-1:0];
        end
    end

    // Completion and read return.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            ack_q    <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            ack_q    <= rd_last | wr_last;
            rvalid_q <= rd_last;
            if (rd_last) rdata_q <= merged;
        end
    end

    assign ack             = ack_q;
    assign rd_valid        = rvalid_q;
    assign rd_data         = rdata_q;
    assign mem_addr        = addr_q;
    assign mem_sel_n       = ~ce_act;
    assign mem_sel         = ce_act;
    assign mem_rd_en_n     = ~oe_act;
    assign mem_wr_strobe_n = ~we_act;
    assign mem_hi_lane_n   = ~(lane_act & be_q[LANES-1]);
    assign mem_lo_lane_n   = ~(lane_act & be_q[0]);
    assign mem_dq_out      = wdata_q;
    assign mem_dq_oe       = drive;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_rd_en_n,
    input logic              mem_wr_strobe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    assert_read_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en_n |-> (!mem_sel_n && mem_sel && mem_wr_strobe_n));

    assert_read_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_en_n && $past(!mem_rd_en_n)) |-> $stable(mem_addr));

    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_valid_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ack);

    assert_strobe_no_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_strobe_n |-> (mem_rd_en_n && !mem_sel_n && mem_sel));

    assert_drive_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_wr_strobe_n && mem_rd_en_n));

    assert_release_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> ($rose(mem_wr_strobe_n) && $stable(mem_dq_out)));

    assert_turnaround_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_rd_en_n) && $past(mem_rd_en_n, 2)));

endmodule

bind sram_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .ack             (ack),
    .rd_valid        (rd_valid),
    .mem_addr        (mem_addr),
    .mem_sel_n       (mem_sel_n),
    .mem_sel         (mem_sel),
    .mem_rd_en_n     (mem_rd_en_n),
    .mem_wr_strobe_n (mem_wr_strobe_n),
    .mem_dq_out      (mem_dq_out),
    .mem_dq_oe       (mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

    localparam int TB_CLK_NS = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + TB_CLK_NS - 1) / TB_CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD    = mx(mx(cyc(70), cyc(70)), cyc(35));
    localparam int E_FLOAT = cyc(25);
    localparam int E_WP    = mx(mx(cyc(50), cyc(35)), cyc(60) - 1);
    localparam int E_TAIL  = mx(1, cyc(70) - 1 - E_WP);
    localparam int E_RD_LAT = E_RD + 1;
    localparam int E_WR_LAT = 1 + E_WP + E_TAIL + 1;

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [1:0]  be;
        logic [15:0] wd;
        logic [15:0] exp;
    } vec_t;

    localparam int N_VEC = 13;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 18'h00003, 2'b11, 16'h1234, 16'h0000},
        '{1'b0, 18'h00003, 2'b11, 16'h0000, 16'h1234},
        '{1'b1, 18'h00003, 2'b10, 16'hABCD, 16'h0000},
        '{1'b0, 18'h00003, 2'b11, 16'h0000, 16'hAB34},
        '{1'b1, 18'h00003, 2'b01, 16'h5566, 16'h0000},
        '{1'b0, 18'h00003, 2'b10, 16'h0000, 16'hAB00},
        '{1'b0, 18'h00003, 2'b01, 16'h0000, 16'h0066},
        '{1'b1, 18'h3FFF5, 2'b11, 16'hFFFF, 16'h0000},
        '{1'b0, 18'h3FFF5, 2'b11, 16'h0000, 16'hFFFF},
        '{1'b0, 18'h00009, 2'b11, 16'h0000, 16'h0F09},
        '{1'b0, 18'h00009, 2'b00, 16'h0000, 16'h0000},
        '{1'b1, 18'h00000, 2'b00, 16'hDEAD, 16'h0000},
        '{1'b0, 18'h00000, 2'b11, 16'h0000, 16'h0F00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ack;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_sel_n;
    logic        mem_sel;
    logic        mem_rd_en_n;
    logic        mem_wr_strobe_n;
    logic        mem_hi_lane_n;
    logic        mem_lo_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_dq_oe;

    always #(TB_CLK_NS / 2) clk = ~clk;

    sram_ctrl u_sram_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req             (req),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .req_be          (req_be),
        .ack             (ack),
        .rd_valid        (rd_valid),
        .rd_data         (rd_data),
        .mem_addr        (mem_addr),
        .mem_sel_n       (mem_sel_n),
        .mem_sel         (mem_sel),
        .mem_rd_en_n     (mem_rd_en_n),
        .mem_wr_strobe_n (mem_wr_strobe_n),
        .mem_hi_lane_n   (mem_hi_lane_n),
        .mem_lo_lane_n   (mem_lo_lane_n),
        .mem_dq_out      (mem_dq_out),
        .mem_dq_in       (mem_dq_in),
        .mem_dq_oe       (mem_dq_oe)
    );

    // Memory model: 16 words on the low address bits, junk on unselected lanes.
    logic [15:0] model [16];
    wire         msel = !mem_sel_n && mem_sel;
    wire  [3:0]  midx = mem_addr[3:0];

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 16'h0F00 + 16'(i);
    end

    assign mem_dq_in = (msel && !mem_rd_en_n && mem_wr_strobe_n)
        ? {mem_hi_lane_n ? 8'hA5 : model[midx][15:8], mem_lo_lane_n ? 8'hA5 : model[midx][7:0]}
        : 16'h5A5A;

    always @(posedge mem_wr_strobe_n) begin
        if (msel) begin
            if (!mem_hi_lane_n) model[midx][15:8] <= mem_dq_out[15:8];
            if (!mem_lo_lane_n) model[midx][7:0]  <= mem_dq_out[7:0];
        end
    end

    // Pin monitor, sampled at falling edges.
    int          n_tests = 0;
    int          n_fail = 0;
    int          cyc_n = 0;
    int          n_we, n_drv, n_oe, n_bad_drv, n_addr_bad;
    int          last_oe = 0;
    int          first_drv = -1;
    logic [17:0] mon_addr = '0;
    bit          done = 0;

    always @(negedge clk) begin
        cyc_n++;
        if (!mem_wr_strobe_n) n_we++;
        if (mem_dq_oe) n_drv++;
        if (!mem_rd_en_n) n_oe++;
        if (mem_dq_oe && mem_wr_strobe_n) n_bad_drv++;
        if (msel && mem_addr !== mon_addr) n_addr_bad++;
        if (!mem_rd_en_n) last_oe = cyc_n;
        if (mem_dq_oe && first_drv < 0) first_drv = cyc_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_we = 0; n_drv = 0; n_oe = 0; n_bad_drv = 0; n_addr_bad = 0;
    endtask

    task automatic idle_pins(input string tag);
        chk({tag, " pins"}, {mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_strobe_n,
                              mem_hi_lane_n, mem_lo_lane_n, mem_dq_oe, ack, rd_valid},
            9'b101111000);
    endtask

    // One request: returns latency and checks strobes afterwards.
    task automatic do_op(input logic wr, input logic [17:0] a, input logic [1:0] be,
                         input logic [15:0] wd, input logic [15:0] ex);
        int lat;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        mon_addr = a;
        #1 clr_mon();
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 60);
        #1;
        req = 1'b0;
        if (wr) begin
            chk("R5 write ack latency", lat, E_WR_LAT);
            chk("R3 no rd_valid on write", rd_valid, 1'b0);
        end else begin
            chk("R3 read ack latency", lat, E_RD_LAT);
            chk("R3 rd_valid with ack", rd_valid, 1'b1);
            chk("R4 R7 read data", rd_data, ex);
        end
        @(negedge clk);
        #1 chk("R9 ack one cycle", ack, 1'b0);
        repeat (E_FLOAT + 1) @(negedge clk);
        #1;
        chk("R2 address held", n_addr_bad, 0);
        if (wr) begin
            chk("R5 strobe width", n_we, E_WP);
            chk("R6 drive cycles", n_drv, E_WP);
            chk("R6 drive outside strobe", n_bad_drv, 0);
            chk("R5 oe high in write", n_oe, 0);
        end else begin
            chk("R2 oe low cycles", n_oe, E_RD);
            chk("R2 no strobe in read", n_we, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 idle_pins("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1 idle_pins("R1 after reset");

        for (int i = 0; i < N_VEC; i++) begin
            do_op(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wd, VECS[i].exp);
        end

        // R9: fields changed mid-read do not affect the running cycle.
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_addr = 18'h9; req_be = 2'b11; req_wdata = 16'h0;
        mon_addr = 18'h9;
        #1 clr_mon();
        repeat (3) @(negedge clk);
        req_write = 1'b1; req_addr = 18'h5; req_be = 2'b01; req_wdata = 16'hBEEF;
        while (!ack) @(negedge clk);
        #1;
        req = 1'b0;
        chk("R9 read data unchanged", rd_data, 16'h0F09);
        repeat (E_FLOAT + 2) @(negedge clk);
        #1;
        chk("R9 no strobe after field change", n_we, 0);
        chk("R9 address held", n_addr_bad, 0);

        // R8: write held pending behind a read.
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_addr = 18'h3; req_be = 2'b11;
        mon_addr = 18'h3;
        first_drv = -1;
        while (!ack) @(negedge clk);
        #1;
        chk("R8 read before turnaround", rd_data, 16'hAB66);
        req_write = 1'b1; req_addr = 18'h1; req_be = 2'b11; req_wdata = 16'h7777;
        mon_addr = 18'h1;
        @(negedge clk);
        while (!ack) @(negedge clk);
        #1;
        req = 1'b0;
        chk("R8 turnaround gap", first_drv - last_oe, E_FLOAT + 3);
        repeat (E_FLOAT + 1) @(negedge clk);
        do_op(1'b0, 18'h1, 2'b11, 16'h0, 16'h7777);

        // R1: reset in the middle of a write strobe.
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 18'hC; req_be = 2'b11; req_wdata = 16'h4242;
        mon_addr = 18'hC;
        repeat (3) @(negedge clk);
        #1 chk("R5 strobe low mid write", mem_wr_strobe_n, 1'b0);
        rst_n = 1'b0;
        req = 1'b0;
        @(negedge clk);
        #1 idle_pins("R1 reset mid write");
        rst_n = 1'b1;
        do_op(1'b0, 18'h9, 2'b11, 16'h0, 16'h0F09);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule